// File: doc/BRIEF.md
# Keyed Write Protection Guard

This block stands between a host write port and a two-bank register file. It holds a bank selector, two key registers and a lock register with one bit per monitor channel. For every incoming write, it decodes the address into a protection group, or into a monitor channel. It then either forwards the write to the register file one cycle later, or drops it and pulses a blocked flag.

A group counts as locked only when its bit is set in both key registers. Each key can be written on its own, so a single stray write cannot lock or unlock a group. A monitor-channel write also needs its own channel's lock bit to be set before it is refused. The lock bits all come out of reset set, so the channels are locked whenever both keys carry the monitor bit.

The bank selector, the keys and the channel locks live inside the guard, and a write to them is never refused. Software can therefore always unlock the device. Writes to these control registers are not forwarded. A write changes the decision for the very next write.

Top module: `keyed_write_guard`

## Requirements
- R1: After reset the bank is 0, both keys are 0 and every channel lock bit is 1, and the rf_we, wr_blocked, rf_bank, rf_addr and rf_data outputs are all 0.
- R2: A write to the IEN group (bank 1, 0x40-0x47), the CFG group (bank 1, 0x50-0x5F) or the WRKC group (bank 1, 0x60-0x67) is refused when that group's key bit (IEN bit 2, CFG bit 3, WRKC bit 5) is 1 in both keys. A refused write gives wr_blocked high for exactly one cycle and rf_we low.
- R3: If a group's key bit is 0 in either key, writes to that group are forwarded.
- R4: In bank 1, channel k (k = 0, 1, 2) occupies offsets 0x30+4k to 0x33+4k. Its lock is bit 1+k of the lock register. A write to a channel is refused only when key bit 1 (MON) is set in both keys and that channel's lock bit is 1.
- R5: The control registers sit at offsets 0xF0 (bank, bit 0), 0xF1 (key A), 0xF2 (key B) and 0xF3 (channel locks). They are reachable in either bank and are always written. They never raise rf_we or wr_blocked, and their new value governs the write in the next cycle.
- R6: A write to any offset outside the groups, the channels, the free range and the control registers has no effect: rf_we and wr_blocked stay low.
- R7: Bit 0 of 0xF0 selects the bank, and its other bits are ignored. The protected groups and channels exist only in bank 1. Bank 0 offsets 0x10-0x2F are forwarded whatever the keys hold, and rf_bank carries the bank that was in force for the write.
- R8: A forwarded write raises rf_we for one cycle, in the cycle after the strobe, with rf_addr and rf_data equal to the strobed address and data. Without a strobe, rf_we stays low.
- R9: Key bits other than 5, 3, 2 and 1 are reserved and ignored, so writing them locks nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the host |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 8 | Write data |
| rf_we | output | 1 | Forwarded write enable to the register file (one cycle) |
| rf_bank | output | 1 | Bank of the forwarded write |
| rf_addr | output | 8 | Offset of the forwarded write |
| rf_data | output | 8 | Data of the forwarded write |
| wr_blocked | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench sets the monitor bit in one key at a time. A design that ORs the keys instead of ANDing them would then refuse writes that must pass. It clears a single channel's lock bit and writes to the neighbouring channels, which catches a wrong channel-to-bit mapping or a lock that ignores the channel. It checks that the locks and keys come out of reset with their proper values, that a key value holding only reserved bits locks nothing, and that the upper bits written to the bank register do not move the bank. It also issues a control write back to back with a protected write, so a guard that applied the new key one cycle late would forward or refuse the wrong write.

// File: rtl/kwg_pkg.sv
package kwg_pkg;

   // protection class of a decoded write
   typedef enum logic [2:0] {
      GRP_NONE = 3'd0,
      GRP_FREE = 3'd1,
      GRP_CTRL = 3'd2,
      GRP_MON  = 3'd3,
      GRP_IEN  = 3'd4,
      GRP_CFG  = 3'd5,
      GRP_WRKC = 3'd6
   } grp_e;

   // key bit positions, shared by both key registers
   localparam int KEY_MON_BIT  = 1;
   localparam int KEY_IEN_BIT  = 2;
   localparam int KEY_CFG_BIT  = 3;
   localparam int KEY_WRKC_BIT = 5;

   // control register indices inside the control window
   localparam logic [1:0] CTRL_BANK = 2'd0;
   localparam logic [1:0] CTRL_KEYA = 2'd1;
   localparam logic [1:0] CTRL_KEYB = 2'd2;
   localparam logic [1:0] CTRL_LOCK = 2'd3;

endpackage

// File: rtl/kwg_addr_decode.sv
module kwg_addr_decode
   import kwg_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int NUM_CH        = 3,
   parameter int CH_IDX_W      = 2,
   parameter int MON_BASE      = 'h30,
   parameter int CH_SPAN       = 4,
   parameter int IEN_BASE      = 'h40,
   parameter int IEN_SPAN      = 8,
   parameter int CFG_BASE      = 'h50,
   parameter int CFG_SPAN      = 16,
   parameter int WRKC_BASE     = 'h60,
   parameter int WRKC_SPAN     = 8,
   parameter int FREE_BASE     = 'h10,
   parameter int FREE_SPAN     = 32,
   parameter int CTRL_BASE     = 'hF0,
   parameter bit CTRL_ANY_BANK = 1'b1
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                bank,
   output grp_e                grp,
   output logic [CH_IDX_W-1:0] ch_idx,
   output logic [1:0]          ctrl_idx
);

   localparam int CTRL_SPAN = 4;

   function automatic logic in_win(input int a, input int base, input int span);
      return (a >= base) && (a < base + span);
   endfunction

   int   a_i;
   logic ctrl_win;
   logic ctrl_hit;
   logic [NUM_CH-1:0] ch_hit;

   assign a_i      = int'(addr);
   assign ctrl_win = in_win(a_i, CTRL_BASE, CTRL_SPAN);
   assign ctrl_idx = addr[1:0];

   // variant: control window visible in both banks or only in bank 0
   generate
      if (CTRL_ANY_BANK) begin : g_ctrl_any
         assign ctrl_hit = ctrl_win;
      end else begin : g_ctrl_b0
         assign ctrl_hit = ctrl_win && !bank;
      end
   endgenerate

   // one window per monitor channel, bank 1 only
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign ch_hit[c] = bank && in_win(a_i, MON_BASE + c * CH_SPAN, CH_SPAN);
      end
   endgenerate

   always_comb begin
      ch_idx = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (ch_hit[c]) ch_idx = CH_IDX_W'(c);
      end
   end

   always_comb begin
      grp = GRP_NONE;
      if (ctrl_hit) begin
         grp = GRP_CTRL;
      end else if (!bank) begin
         if (in_win(a_i, FREE_BASE, FREE_SPAN)) grp = GRP_FREE;
      end else begin
         if (|ch_hit)                                grp = GRP_MON;
         else if (in_win(a_i, IEN_BASE, IEN_SPAN))   grp = GRP_IEN;
         else if (in_win(a_i, CFG_BASE, CFG_SPAN))   grp = GRP_CFG;
         else if (in_win(a_i, WRKC_BASE, WRKC_SPAN)) grp = GRP_WRKC;
      end
   end

endmodule

// File: rtl/kwg_ctrl_regs.sv
module kwg_ctrl_regs
   import kwg_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int NUM_CH   = 3,
   parameter int LOCK_LSB = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              is_ctrl,
   input  logic [1:0]        ctrl_idx,
   input  logic [DATA_W-1:0] data,
   output logic              bank_q,
   output logic [DATA_W-1:0] key_a,
   output logic [DATA_W-1:0] key_b,
   output logic [NUM_CH-1:0] ch_lock
);

   localparam logic [DATA_W-1:0] KEY_MASK = DATA_W'((1 << KEY_MON_BIT) | (1 << KEY_IEN_BIT)
                                                  | (1 << KEY_CFG_BIT) | (1 << KEY_WRKC_BIT));

   logic take;
   assign take = wr_en && is_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q  <= 1'b0;
         key_a   <= '0;
         key_b   <= '0;
         ch_lock <= '1;
      end else if (take) begin
         case (ctrl_idx)
            CTRL_BANK: bank_q  <= data[0];
            CTRL_KEYA: key_a   <= data & KEY_MASK;
            CTRL_KEYB: key_b   <= data & KEY_MASK;
            default:   ch_lock <= data[LOCK_LSB +: NUM_CH];
         endcase
      end
   end

   // R7: bank only moves on a write to the bank register
   a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && ctrl_idx == CTRL_BANK) |=> $stable(bank_q));

   // R9: reserved key bits never become set
   a_r9_key_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      take && ctrl_idx == CTRL_KEYA |=> ((key_a & ~KEY_MASK) == '0));

endmodule

// File: rtl/kwg_gate.sv
module kwg_gate
   import kwg_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int NUM_CH   = 3,
   parameter int CH_IDX_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   data,
   input  logic                bank,
   input  grp_e                grp,
   input  logic [CH_IDX_W-1:0] ch_idx,
   input  logic [DATA_W-1:0]   key_a,
   input  logic [DATA_W-1:0]   key_b,
   input  logic [NUM_CH-1:0]   ch_lock,
   output logic                rf_we,
   output logic                rf_bank,
   output logic [ADDR_W-1:0]   rf_addr,
   output logic [DATA_W-1:0]   rf_data,
   output logic                blocked
);

   logic [DATA_W-1:0] both;
   logic              fwd;
   logic              locked;

   assign both = key_a & key_b;
   assign fwd  = wr_en && (grp != GRP_NONE) && (grp != GRP_CTRL);

   always_comb begin
      case (grp)
         GRP_MON:  locked = both[KEY_MON_BIT] && ch_lock[ch_idx];
         GRP_IEN:  locked = both[KEY_IEN_BIT];
         GRP_CFG:  locked = both[KEY_CFG_BIT];
         GRP_WRKC: locked = both[KEY_WRKC_BIT];
         default:  locked = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_we   <= 1'b0;
         blocked <= 1'b0;
         rf_bank <= 1'b0;
         rf_addr <= '0;
         rf_data <= '0;
      end else begin
         rf_we   <= fwd && !locked;
         blocked <= fwd && locked;
         if (fwd) begin
            rf_bank <= bank;
            rf_addr <= addr;
            rf_data <= data;
         end
      end
   end

   // R2: forward and refuse are exclusive
   a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && blocked));

   // R2: a refusal traces back to a strobe
   a_r2_blk_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> $past(wr_en));

   // R8: forwarded address is the strobed one
   a_r8_addr_follow: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (rf_addr == $past(addr)) && $past(wr_en));

   // R4: an unlocked channel is never refused
   a_r4_unlocked_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && grp == GRP_MON && !ch_lock[ch_idx]) |=> rf_we);

endmodule

// File: rtl/keyed_write_guard.sv
module keyed_write_guard
   import kwg_pkg::*;
#(
   parameter int ADDR_W        = 8,
   parameter int DATA_W        = 8,
   parameter int NUM_CH        = 3,
   parameter int LOCK_LSB      = 1,
   parameter int MON_BASE      = 'h30,
   parameter int CH_SPAN       = 4,
   parameter int IEN_BASE      = 'h40,
   parameter int IEN_SPAN      = 8,
   parameter int CFG_BASE      = 'h50,
   parameter int CFG_SPAN      = 16,
   parameter int WRKC_BASE     = 'h60,
   parameter int WRKC_SPAN     = 8,
   parameter int FREE_BASE     = 'h10,
   parameter int FREE_SPAN     = 32,
   parameter int CTRL_BASE     = 'hF0,
   parameter bit CTRL_ANY_BANK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              rf_we,
   output logic              rf_bank,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_data,
   output logic              wr_blocked
);

   localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   // elaboration-time parameter checks
   generate
      if (DATA_W < KEY_WRKC_BIT + 1) begin : g_bad_data_w
         $error("DATA_W too narrow for key layout");
      end
      if (NUM_CH < 1 || LOCK_LSB + NUM_CH > DATA_W) begin : g_bad_ch
         $error("channel lock bits do not fit DATA_W");
      end
      if (CTRL_BASE % 4 != 0 || CTRL_BASE + 4 > (1 << ADDR_W)) begin : g_bad_ctrl
         $error("CTRL_BASE must be 4-aligned and inside the address space");
      end
      if (CH_SPAN < 1) begin : g_bad_span
         $error("CH_SPAN must be positive");
      end
   endgenerate

   grp_e                grp;
   logic [CH_IDX_W-1:0] ch_idx;
   logic [1:0]          ctrl_idx;
   logic                bank_q;
   logic [DATA_W-1:0]   key_a;
   logic [DATA_W-1:0]   key_b;
   logic [NUM_CH-1:0]   ch_lock;

   kwg_addr_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W),
      .MON_BASE(MON_BASE), .CH_SPAN(CH_SPAN),
      .IEN_BASE(IEN_BASE), .IEN_SPAN(IEN_SPAN),
      .CFG_BASE(CFG_BASE), .CFG_SPAN(CFG_SPAN),
      .WRKC_BASE(WRKC_BASE), .WRKC_SPAN(WRKC_SPAN),
      .FREE_BASE(FREE_BASE), .FREE_SPAN(FREE_SPAN),
      .CTRL_BASE(CTRL_BASE), .CTRL_ANY_BANK(CTRL_ANY_BANK)
   ) u_dec (
      .addr    (wr_addr),
      .bank    (bank_q),
      .grp     (grp),
      .ch_idx  (ch_idx),
      .ctrl_idx(ctrl_idx)
   );

   kwg_ctrl_regs #(
      .DATA_W(DATA_W), .NUM_CH(NUM_CH), .LOCK_LSB(LOCK_LSB)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .is_ctrl (grp == GRP_CTRL),
      .ctrl_idx(ctrl_idx),
      .data    (wr_data),
      .bank_q  (bank_q),
      .key_a   (key_a),
      .key_b   (key_b),
      .ch_lock (ch_lock)
   );

   kwg_gate #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_IDX_W(CH_IDX_W)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .addr   (wr_addr),
      .data   (wr_data),
      .bank   (bank_q),
      .grp    (grp),
      .ch_idx (ch_idx),
      .key_a  (key_a),
      .key_b  (key_b),
      .ch_lock(ch_lock),
      .rf_we  (rf_we),
      .rf_bank(rf_bank),
      .rf_addr(rf_addr),
      .rf_data(rf_data),
      .blocked(wr_blocked)
   );

   // R5: control writes are silent at the register-file side
   a_r5_ctrl_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_addr) >= CTRL_BASE && int'(wr_addr) < CTRL_BASE + 4 && CTRL_ANY_BANK)
      |=> !rf_we && !wr_blocked);

   // R8: no strobe, no forwarded write
   a_r8_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !rf_we);

endmodule

// File: tb/keyed_write_guard_bench.sv
module keyed_write_guard_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       rf_we, rf_bank, wr_blocked;
   logic [7:0] rf_addr, rf_data;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   keyed_write_guard u_keyed_write_guard (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rf_we(rf_we), .rf_bank(rf_bank), .rf_addr(rf_addr), .rf_data(rf_data),
      .wr_blocked(wr_blocked)
   );

   // {addr, data, exp_we, exp_blk, exp_bank, req}
   localparam int NV = 32;
   localparam logic [22:0] VEC [NV] = '{
      {8'h12, 8'h04, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 bank 0 free range
      {8'h30, 8'h00, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 channel offset absent in bank 0
      {8'hF0, 8'h01, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 select bank 1
      {8'h30, 8'h11, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 no keys
      {8'hF1, 8'h02, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 key A MON
      {8'h31, 8'h22, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 one key only
      {8'hF2, 8'h02, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 key B MON
      {8'h32, 8'h33, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 ch0 locked
      {8'h3A, 8'h44, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 ch2 locked
      {8'hF3, 8'h0C, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 unlock ch0 only
      {8'h33, 8'h55, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 ch0 passes
      {8'h36, 8'h66, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 ch1 still locked
      {8'h40, 8'h77, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 IEN not keyed
      {8'hF1, 8'h2E, 1'b0, 1'b0, 1'b0, 4'd5},
      {8'hF2, 8'h2C, 1'b0, 1'b0, 1'b0, 4'd5},
      {8'h44, 8'h01, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 IEN
      {8'h5F, 8'h02, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 CFG
      {8'h67, 8'h03, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 WRKC
      {8'h38, 8'h04, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 MON only in key A now
      {8'h3C, 8'h05, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 past last channel
      {8'h68, 8'h06, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 past WRKC
      {8'h12, 8'h07, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 free range absent in bank 1
      {8'hF0, 8'h00, 1'b0, 1'b0, 1'b0, 4'd5},
      {8'h44, 8'h08, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 IEN absent in bank 0
      {8'h2F, 8'h09, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 free despite keys
      {8'hF2, 8'hD1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 reserved bits only
      {8'hF0, 8'hFF, 1'b0, 1'b0, 1'b0, 4'd7},
      {8'h50, 8'h0A, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 CFG open
      {8'h60, 8'h0B, 1'b1, 1'b0, 1'b1, 4'd9},  // R9 WRKC open
      {8'hF0, 8'hFE, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 only bit 0 counts
      {8'h10, 8'h0C, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 back in bank 0
      {8'hF4, 8'h0D, 1'b0, 1'b0, 1'b0, 4'd6}   // R6 beyond control window
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // drive one strobe; return at the negedge where its result is visible
   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state at the outputs
      check(!rf_we && !wr_blocked && !rf_bank && rf_addr == 0 && rf_data == 0,
            "R1", "outputs in reset", {rf_we, wr_blocked, rf_bank}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [22:0] v;
         string rq;
         v = VEC[i];
         rq = $sformatf("R%0d", v[3:0]);
         do_write(v[22:15], v[14:7]);
         check(rf_we == v[6] && wr_blocked == v[5], rq,
               $sformatf("row %0d we/blk", i), {rf_we, wr_blocked}, {v[6], v[5]});
         if (v[6]) begin
            // R8 payload of forwarded write
            check(rf_addr == v[22:15] && rf_data == v[14:7] && rf_bank == v[4], "R8",
                  $sformatf("row %0d payload", i), {rf_bank, rf_addr, rf_data},
                  {v[4], v[22:15], v[14:7]});
         end
      end

      // R1 lock bits default to ones, keys to zero
      apply_reset();
      check(!rf_we && !wr_blocked && rf_addr == 0, "R1", "outputs after reset",
            {rf_we, wr_blocked}, 0);
      do_write(8'hF0, 8'h01);
      do_write(8'h34, 8'h21);
      check(rf_we && !wr_blocked, "R1", "keys reset to zero", {rf_we, wr_blocked}, 2);
      do_write(8'hF1, 8'h02);
      do_write(8'hF2, 8'h02);
      do_write(8'h34, 8'h22);
      check(!rf_we && wr_blocked, "R1", "channel lock resets set", {rf_we, wr_blocked}, 1);
      @(negedge clk);
      check(!wr_blocked && !rf_we, "R2", "blocked is a single pulse", wr_blocked, 0);

      // R5 back-to-back: unlock then channel write in the next cycle
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'hF3; wr_data = 8'h00;
      @(negedge clk);
      check(!rf_we && !wr_blocked, "R5", "control write silent", {rf_we, wr_blocked}, 0);
      wr_addr = 8'h34; wr_data = 8'h5A;
      @(negedge clk);
      wr_en = 1'b0;
      check(rf_we && !wr_blocked && rf_data == 8'h5A, "R5", "new lock used next cycle",
            {rf_we, wr_blocked, rf_data}, {2'b10, 8'h5A});

      // R8 no strobe, no write
      wr_addr = 8'h30; wr_data = 8'h99;
      @(negedge clk);
      @(negedge clk);
      check(!rf_we && !wr_blocked && rf_data == 8'h5A, "R8", "idle address ignored",
            {rf_we, rf_data}, 8'h5A);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule